// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Controller

This block drives and samples up to 32 general-purpose pins and raises interrupts on pin activity. Software reaches it through a word-wide register port with single-cycle write and read strobes. Each pin can be an output, driven from a stored value, or an input, sampled through a two-stage synchroniser. A pad-level register shows the synchronised input of every pin.

Every pin has its own interrupt logic. A 2-bit trigger selects low level, high level, rising edge or falling edge. An optional any-edge override makes the pin fire on both transitions. A sticky pending bit records each event and is cleared by writing a one to it. A per-pin enable decides whether the pending bit reaches an interrupt line. Two interrupt lines are provided: one for the lower half of the pins and one for the upper half.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the output value, direction, both trigger words, the enable word and the any-edge word read as zero, `pad_oe` is zero and both interrupt lines are low.
- R2: A direction bit of 1 sets `pad_oe[n]` and drives `pad_out[n]` from data bit n. A direction bit of 0 clears `pad_oe[n]`. Bit n of every per-pin word belongs to pin n.
- R3: A read of the data word (offset 0x00) returns the stored bit for output pins and the synchronised pad level for input pins.
- R4: The pad-level word (offset 0x08) returns `pad_in` after a two-flop synchroniser. The pending bit it causes is set one clock later.
- R5: The trigger field for pin n occupies bits 2×(n mod 16)+1 : 2×(n mod 16). It sits in the word at 0x0C for pins 0–15 and in the word at 0x10 for pins 16–31. The codes are 0 = low level, 1 = high level, 2 = rising edge, 3 = falling edge.
- R6: An edge trigger sets the pending bit once per matching transition of the synchronised level. A transition in the other direction sets nothing.
- R7: A level trigger sets the pending bit on every clock while the level is active, so a clear does not last. When a set and a clear of the same bit fall in one clock, the set wins.
- R8: When any-edge bit n (offset 0x1C) is 1, pin n flags both rising and falling transitions, whatever its trigger field holds.
- R9: A pending bit reaches an interrupt line only while its enable bit (offset 0x14) is 1.
- R10: Writing the pending word (offset 0x18) clears each bit written as 1 and keeps each bit written as 0. Without a write, pending bits never drop.
- R11: `irq_lo` is the OR of the enabled pending bits of pins 0–15. `irq_hi` is the same for pins 16–31.
- R12: `rdata` updates on the clock edge after `rd_en` and then holds. A read or write at an offset outside the eight words reads zero and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 6 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| pad_in | input | 32 | Pin input levels |
| pad_out | output | 32 | Pin output values |
| pad_oe | output | 32 | Pin output enables |
| irq_lo | output | 1 | Interrupt line for pins 0–15 |
| irq_hi | output | 1 | Interrupt line for pins 16–31 |

## Verification
The bench checks that edge triggers ignore the opposite transition. A design that decoded the trigger codes the wrong way round would flag falling edges on a rising-only pin. A high-level trigger is cleared while its level is still present, and the pending bit must come straight back. Getting set-over-clear priority wrong leaves the bit low. The split between the two trigger words is probed at pin 17 and pin 1. An off-by-one field position would arm a neighbouring pin instead. The any-edge override and the write-zero-keeps rule of the pending word are each driven so that a wrong design shows a pending word of zero where one bit is expected.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int unsigned OFS_DATA  = 'h00;
  localparam int unsigned OFS_DIR   = 'h04;
  localparam int unsigned OFS_LEVEL = 'h08;
  localparam int unsigned OFS_TRG0  = 'h0C;
  localparam int unsigned OFS_TRG1  = 'h10;
  localparam int unsigned OFS_ENA   = 'h14;
  localparam int unsigned OFS_PEND  = 'h18;
  localparam int unsigned OFS_ANY   = 'h1C;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  typedef struct packed {
    logic data;
    logic dir;
    logic level;
    logic trg0;
    logic trg1;
    logic ena;
    logic pend;
    logic any;
  } reg_sel_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);
  always_comb begin
    sel       = '0;
    sel.data  = (addr == ADDR_W'(OFS_DATA));
    sel.dir   = (addr == ADDR_W'(OFS_DIR));
    sel.level = (addr == ADDR_W'(OFS_LEVEL));
    sel.trg0  = (addr == ADDR_W'(OFS_TRG0));
    sel.trg1  = (addr == ADDR_W'(OFS_TRG1));
    sel.ena   = (addr == ADDR_W'(OFS_ENA));
    sel.pend  = (addr == ADDR_W'(OFS_PEND));
    sel.any   = (addr == ADDR_W'(OFS_ANY));
  end
endmodule

// File: rtl/gpio_ctl_regs.sv
module gpio_ctl_regs
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_t          sel,
  input  logic [WORD_W-1:0] wdata,
  output logic [NPINS-1:0]  data_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  ena_q,
  output logic [NPINS-1:0]  any_q,
  output logic [WORD_W-1:0] trg0_q,
  output logic [WORD_W-1:0] trg1_q
);
  logic [NPINS-1:0]  data_d, dir_d, ena_d, any_d;
  logic [WORD_W-1:0] trg0_d, trg1_d;

  always_comb begin
    data_d = data_q;
    dir_d  = dir_q;
    ena_d  = ena_q;
    any_d  = any_q;
    trg0_d = trg0_q;
    trg1_d = trg1_q;
    if (wr_en) begin
      if (sel.data) data_d = wdata[NPINS-1:0];
      if (sel.dir)  dir_d  = wdata[NPINS-1:0];
      if (sel.ena)  ena_d  = wdata[NPINS-1:0];
      if (sel.any)  any_d  = wdata[NPINS-1:0];
      if (sel.trg0) trg0_d = wdata;
      if (sel.trg1) trg1_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      ena_q  <= '0;
      any_q  <= '0;
      trg0_q <= '0;
      trg1_q <= '0;
    end else if (wr_en) begin
      data_q <= data_d;
      dir_q  <= dir_d;
      ena_q  <= ena_d;
      any_q  <= any_d;
      trg0_q <= trg0_d;
      trg1_q <= trg1_d;
    end
  end
endmodule

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq
  import gpio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  logic [1:0] trig,
  input  logic       any_edge,
  input  logic       clr,
  output logic       pend
);
  logic prev_q;
  logic pend_q, pend_d;
  logic rise, fall, hit;

  always_comb begin
    rise = lvl & ~prev_q;
    fall = ~lvl & prev_q;
    if (any_edge) begin
      hit = rise | fall;
    end else begin
      unique case (trig_e'(trig))
        TRIG_LOW:  hit = ~lvl;
        TRIG_HIGH: hit = lvl;
        TRIG_RISE: hit = rise;
        TRIG_FALL: hit = fall;
        default:   hit = 1'b0;
      endcase
    end
    // a fresh event outranks a clear in the same cycle
    pend_d = hit | (pend_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF   = NPINS / 2;
  localparam int unsigned TW     = 2;

  reg_sel_t          sel;
  logic [NPINS-1:0]  sync_q;
  logic [NPINS-1:0]  data_q, dir_q, ena_q, any_q;
  logic [WORD_W-1:0] trg0_q, trg1_q;
  logic [NPINS-1:0]  stat_q;
  logic [NPINS-1:0]  clr_vec;
  logic [NPINS-1:0]  live;
  logic              stat_wr;
  logic [WORD_W-1:0] rd_d, rdata_q;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (sync_q)
  );

  gpio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (addr),
    .sel  (sel)
  );

  gpio_ctl_regs #(.NPINS(NPINS), .WORD_W(WORD_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .sel    (sel),
    .wdata  (wdata),
    .data_q (data_q),
    .dir_q  (dir_q),
    .ena_q  (ena_q),
    .any_q  (any_q),
    .trg0_q (trg0_q),
    .trg1_q (trg1_q)
  );

  assign stat_wr = wr_en & sel.pend;
  assign clr_vec = stat_wr ? wdata[NPINS-1:0] : '0;

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    logic [TW-1:0] trig_n;
    if (n < HALF) begin : g_lo
      assign trig_n = trg0_q[TW*n +: TW];
    end else begin : g_hi
      assign trig_n = trg1_q[TW*(n-HALF) +: TW];
    end
    gpio_pin_irq u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (sync_q[n]),
      .trig     (trig_n),
      .any_edge (any_q[n]),
      .clr      (clr_vec[n]),
      .pend     (stat_q[n])
    );
  end

  assign live   = stat_q & ena_q;
  assign irq_lo = |live[HALF-1:0];
  assign irq_hi = |live[NPINS-1:HALF];

  assign pad_out = data_q;
  assign pad_oe  = dir_q;

  always_comb begin
    rd_d = '0;
    unique case (1'b1)
      sel.data:  rd_d[NPINS-1:0] = (dir_q & data_q) | (~dir_q & sync_q);
      sel.dir:   rd_d[NPINS-1:0] = dir_q;
      sel.level: rd_d[NPINS-1:0] = sync_q;
      sel.trg0:  rd_d            = trg0_q;
      sel.trg1:  rd_d            = trg1_q;
      sel.ena:   rd_d[NPINS-1:0] = ena_q;
      sel.pend:  rd_d[NPINS-1:0] = stat_q;
      sel.any:   rd_d[NPINS-1:0] = any_q;
      default:   rd_d            = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rd_d;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int unsigned NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_lo,
  input logic             irq_hi,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] ena_q,
  input logic [NPINS-1:0] stat_q,
  input logic [NPINS-1:0] dir_q,
  input logic [NPINS-1:0] data_q,
  input logic             stat_wr
);
  localparam int unsigned HALF = NPINS / 2;

  AST_IRQ_LO_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> (|ena_q[HALF-1:0])); // R9

  AST_IRQ_HI_FROM_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> (|stat_q[NPINS-1:HALF])); // R11

  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe == dir_q); // R2

  AST_OUT_FOLLOWS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    pad_out == data_q); // R2

  AST_PENDING_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stat_wr) |-> ((stat_q & $past(stat_q)) == $past(stat_q))); // R10
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq_lo  (irq_lo),
  .irq_hi  (irq_hi),
  .pad_oe  (pad_oe),
  .pad_out (pad_out),
  .ena_q   (ena_q),
  .stat_q  (stat_q),
  .dir_q   (dir_q),
  .data_q  (data_q),
  .stat_wr (stat_wr)
);

// File: tb/tb_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_irq_ctrl;
  localparam int NP = 32;
  localparam int AW = 6;
  localparam logic [AW-1:0] A_DATA = 6'h00, A_DIR = 6'h04, A_LVL = 6'h08,
    A_TRG0 = 6'h0C, A_TRG1 = 6'h10, A_ENA = 6'h14, A_PEND = 6'h18, A_ANY = 6'h1C;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, rd_en;
  logic [AW-1:0] addr;
  logic [31:0] wdata, rdata;
  logic [NP-1:0] pad_in, pad_out, pad_oe;
  logic irq_lo, irq_hi;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] v;

  always #2 clk = ~clk;

  gpio_irq_ctrl #(.NPINS(NP), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi));

  // {offset, write value, expected read-back}
  localparam logic [69:0] VEC [6] = '{
    {A_DIR,  32'h0000FFFF, 32'h0000FFFF},
    {A_ENA,  32'hA5A5A5A5, 32'hA5A5A5A5},
    {A_ANY,  32'h12345678, 32'h12345678},
    {A_TRG0, 32'hDEADBEEF, 32'hDEADBEEF},
    {A_TRG1, 32'h0F0F0F0F, 32'h0F0F0F0F},
    {6'h20,  32'hFFFFFFFF, 32'h00000000}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic rdchk(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
    logic [31:0] r;
    rd(a, r);
    check(r === exp, req, r, exp);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; pad_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(pad_oe === '0, "R1 oe", pad_oe, 0);
    check({irq_lo, irq_hi} === 2'b00, "R1 irq", {30'd0, irq_lo, irq_hi}, 0);
    rdchk(A_DATA, 0, "R1 data");
    rdchk(A_ENA, 0, "R1 enable");
    rdchk(A_ANY, 0, "R1 any-edge");
    rdchk(A_TRG1, 0, "R1 trig1");
    check(rdata === 0, "R12 rdata holds", rdata, 0);

    // R12 register table walk
    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][69:64], VEC[i][63:32]);
      rdchk(VEC[i][69:64], VEC[i][31:0], "R12 readback");
    end
    wr(A_ENA, 0); wr(A_ANY, 0);

    // R2 R3 R4 direction and data mixing
    wr(A_DATA, 32'h12345678);
    check(pad_oe === 32'h0000FFFF, "R2 oe", pad_oe, 32'h0000FFFF);
    check(pad_out === 32'h12345678, "R2 out", pad_out, 32'h12345678);
    pad_in = 32'hABCD0000;
    settle();
    rdchk(A_DATA, 32'hABCD5678, "R3 mixed read");
    rdchk(A_LVL, 32'hABCD0000, "R4 pad level");

    // interrupt setup: lower half rising, upper half falling
    pad_in = 0;
    wr(A_DIR, 0); wr(A_DATA, 0);
    wr(A_TRG0, 32'hAAAAAAAA); wr(A_TRG1, 32'hFFFFFFFF);
    settle();
    wr(A_PEND, 32'hFFFFFFFF);
    rdchk(A_PEND, 0, "R10 clear all");

    pad_in = 32'h8; settle();
    rdchk(A_PEND, 32'h8, "R6 rising pin3");
    check(irq_lo === 1'b0, "R9 masked", {31'd0, irq_lo}, 0);
    wr(A_ENA, 32'h8);
    check(irq_lo === 1'b1 && irq_hi === 1'b0, "R11 low line", {30'd0, irq_hi, irq_lo}, 1);
    wr(A_PEND, 32'h0);
    rdchk(A_PEND, 32'h8, "R10 write zero keeps");
    wr(A_PEND, 32'h8);
    check(irq_lo === 1'b0, "R10 cleared line", {31'd0, irq_lo}, 0);
    pad_in = 0; settle();
    rdchk(A_PEND, 0, "R6 falling ignored on rising pin");

    pad_in = 32'h00100000; settle();
    rdchk(A_PEND, 0, "R5 rising ignored on falling pin20");
    pad_in = 0; settle();
    rdchk(A_PEND, 32'h00100000, "R5 falling pin20");
    wr(A_ENA, 32'h00100000);
    check(irq_hi === 1'b1 && irq_lo === 1'b0, "R11 high line", {30'd0, irq_hi, irq_lo}, 2);
    wr(A_PEND, 32'hFFFFFFFF); wr(A_ENA, 0);

    // R7 high level on pin17 (upper word, bits 3:2 = 1)
    wr(A_TRG1, 32'hFFFFFFF7);
    pad_in = 32'h00020000; settle();
    wr(A_PEND, 32'hFFFFFFFF);
    rdchk(A_PEND, 32'h00020000, "R7 high level re-sets");
    pad_in = 0; settle();
    wr(A_PEND, 32'hFFFFFFFF);
    rdchk(A_PEND, 0, "R7 level gone");
    wr(A_TRG1, 32'hFFFFFFFF);

    // R7 low level on pin1 (lower word, bits 3:2 = 0)
    wr(A_TRG0, 32'hAAAAAAA2);
    wr(A_PEND, 32'hFFFFFFFF);
    rdchk(A_PEND, 32'h2, "R7 low level pin1");
    wr(A_ENA, 32'h2);
    check(irq_lo === 1'b1, "R9 enabled level", {31'd0, irq_lo}, 1);
    wr(A_ENA, 0); wr(A_TRG0, 32'hAAAAAAAA);
    wr(A_PEND, 32'hFFFFFFFF);
    rdchk(A_PEND, 0, "R10 clean");

    // R8 any-edge on pin5 overrides its rising-only field
    wr(A_ANY, 32'h20);
    pad_in = 32'h20; settle();
    rdchk(A_PEND, 32'h20, "R8 rising");
    wr(A_PEND, 32'h20);
    pad_in = 0; settle();
    rdchk(A_PEND, 32'h20, "R8 falling");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule